// File: doc/BRIEF.md
# Instruction skip-pattern sequencer

This block decides, one issue slot at a time, whether the instruction in that slot takes effect. A skip instruction loads a pattern of bits. Each later slot uses up the lowest remaining bit, and a 1 turns that slot's instruction into a cancelled one. The block sits beside the issue stage of a small processor. Fetch, decode and the interrupt controller stay outside it and reach it only through per-slot handshake inputs.

There are two skip styles. In the cancelling style, every skipped instruction still occupies its slot but has no effect. In the fast style, when code runs from local memory, the block reports a program-counter increment that steps over whole runs of skipped instructions at once. From shared memory the fast style falls back to cancelling in place.

The block also has four further duties. An executed call freezes the remaining bits until the matching return, and the frozen patterns are kept on a small nesting stack. Skipping is held while an interrupt service routine runs. Interrupt entry is refused whenever the coming slot would be cancelled. A status word gives a preview of the pending bits.

Top module: `skip_seq`

## Requirements
- R1: The pattern is used lowest bit first. When a slot is valid, no service routine runs and the current bit is 1, `cancel` is high in that same cycle. When the bit is 0 the instruction executes. In the cancelling style each valid slot uses up exactly one bit, and `pc_adv` is 1.
- R2: An executed slot with `load_en` replaces any active pattern. Bit 0 of the new pattern applies to the next slot. A load in a cancelled slot is ignored. An all-zero pattern leaves skipping idle.
- R3: In the fast style with `local_mem`=1, a slot that is neither a call nor a return reports `pc_adv` = 1 + N. N is the number of consecutive 1 bits at the bottom of the upcoming pattern, up to PAT_W. Those N bits are used up, so the instructions jumped over never show up as cancelled slots.
- R4: In the fast style with `local_mem`=0, the block behaves exactly like the cancelling style: `pc_adv` is 1 and skipped instructions are cancelled in place.
- R5: While `isr_active` is high, `cancel` stays low, `pc_adv` is 1 for a valid slot and the pattern is held. Loads, calls and returns are ignored during that time.
- R6: `irq_accept` follows `irq_req`, except when no service routine runs and bit 0 of the pattern for the next slot is 1. In that case it is low.
- R7: An executed call saves the bits that remain after the call and clears the live pattern. The subroutine therefore runs without skips. An executed return restores the saved bits. A call in a cancelled slot, or one whose condition failed (`call_exec` low), freezes nothing.
- R8: Calls nest up to DEPTH saved patterns. A return made while the stack is empty only uses up its own bit, and the pattern is otherwise unchanged.
- R9: In `status`, bit 31 is set when any 1 bit remains in the live pattern. Bits 30:22 hold the next nine pending bits, with bit 22 being the next one used. Bits 21:0 are 0.
- R10: After reset the pattern is zero, the stack is empty, the cancelling style is selected and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_valid | input | 1 | An instruction issues in this cycle |
| local_mem | input | 1 | The issuing code runs from local memory |
| load_en | input | 1 | The slot holds a skip-pattern load |
| load_fast | input | 1 | The load selects the fast style |
| load_pat | input | PAT_W | Pattern being loaded |
| call_exec | input | 1 | The slot holds a call whose condition holds |
| ret_exec | input | 1 | The slot holds a return whose condition holds |
| isr_active | input | 1 | An interrupt service routine is running |
| irq_req | input | 1 | The interrupt controller asks to enter a routine |
| cancel | output | 1 | The slot's instruction is cancelled |
| pc_adv | output | $clog2(PAT_W+2) | Program-counter increment for this slot |
| irq_accept | output | 1 | Interrupt entry is allowed this cycle |
| status | output | 32 | Pending-bit preview word |

## Verification
The bench builds the block with its default values, PAT_W=32 and DEPTH=4. With a 32-bit pattern, an all-ones load in the fast style is within reach, and that gives the largest jump of 33. The four-entry stack allows a two-level nested call followed by an ordered unwind. A return made on an empty stack is also covered. The nine-bit preview can be tested both with a pattern whose only 1s lie above the preview window and with one that fills the window completely.

// File: rtl/skip_seq.sv
`timescale 1ns/1ps
module skip_seq #(
  parameter int PAT_W = 32,
  parameter int DEPTH = 4,
  localparam int CW  = $clog2(PAT_W + 1),
  localparam int PCW = $clog2(PAT_W + 2),
  localparam int DW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_valid,
  input  logic             local_mem,
  input  logic             load_en,
  input  logic             load_fast,
  input  logic [PAT_W-1:0] load_pat,
  input  logic             call_exec,
  input  logic             ret_exec,
  input  logic             isr_active,
  input  logic             irq_req,
  output logic             cancel,
  output logic [PCW-1:0]   pc_adv,
  output logic             irq_accept,
  output logic [31:0]      status
);

  logic [PAT_W-1:0] pat, rem, pat_nxt;
  logic             fast_q, fast_nxt;
  logic [PAT_W-1:0] stk [DEPTH];
  logic [DW-1:0]    depth;
  logic             act, ex, do_load, do_call, do_ret, pop_ok, jumping;
  logic [CW-1:0]    run;

  assign act     = slot_valid && !isr_active;
  assign cancel  = act && pat[0];
  assign ex      = act && !pat[0];
  assign do_load = ex && load_en;
  assign do_call = ex && !load_en && call_exec;
  assign do_ret  = ex && !load_en && !call_exec && ret_exec;
  assign pop_ok  = do_ret && (depth != '0);

  assign rem      = do_load ? load_pat : (pat >> 1);
  assign fast_nxt = do_load ? load_fast : fast_q;
  assign jumping  = act && fast_nxt && local_mem && !do_call && !do_ret;

  always_comb begin
    logic stop;
    stop = 1'b0;
    run  = '0;
    if (jumping) begin
      for (int i = 0; i < PAT_W; i++) begin
        if (!stop) begin
          if (rem[i]) run = CW'(i + 1);
          else        stop = 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!act)         pat_nxt = pat;
    else if (do_call) pat_nxt = '0;
    else if (pop_ok)  pat_nxt = stk[0];
    else              pat_nxt = rem >> run;
  end

  assign pc_adv     = slot_valid ? (PCW'(run) + PCW'(1)) : '0;
  assign irq_accept = irq_req && !(!isr_active && pat_nxt[0]);
  assign status     = {|pat, pat[8:0], 22'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat    <= '0;
      fast_q <= 1'b0;
    end else begin
      pat    <= pat_nxt;
      fast_q <= fast_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (do_call) begin
      for (int i = DEPTH - 1; i > 0; i--) stk[i] <= stk[i-1];
      stk[0] <= rem;
      if (depth != DW'(DEPTH)) depth <= depth + 1'b1;
    end else if (pop_ok) begin
      for (int i = 0; i < DEPTH - 1; i++) stk[i] <= stk[i+1];
      stk[DEPTH-1] <= '0;
      depth <= depth - 1'b1;
    end
  end

  assert_jump_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    jumping |=> !pat[0]);
  assert_hub_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !local_mem) |-> pc_adv == PCW'(1));
  assert_isr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isr_active |=> $stable(pat));
  assert_isr_no_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |-> !isr_active);
  assert_irq_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept && !isr_active) |=> !cancel);
  assert_call_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_call |=> (status == 32'd0));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));

endmodule

// File: tb/skip_seq_tb.sv
`timescale 1ns/1ps
module skip_seq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, slot_valid, local_mem, load_en, load_fast, call_exec, ret_exec, isr_active, irq_req;
  logic [31:0] load_pat, status;
  logic cancel, irq_accept;
  logic [5:0] pc_adv;
  int n_chk = 0, n_fail = 0;

  skip_seq u_dut (.clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .local_mem(local_mem),
    .load_en(load_en), .load_fast(load_fast), .load_pat(load_pat), .call_exec(call_exec),
    .ret_exec(ret_exec), .isr_active(isr_active), .irq_req(irq_req), .cancel(cancel),
    .pc_adv(pc_adv), .irq_accept(irq_accept), .status(status));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic quiet;
    slot_valid = 0; load_en = 0; load_fast = 0; load_pat = 0;
    call_exec = 0; ret_exec = 0; isr_active = 0;
  endtask

  task automatic do_reset;
    quiet(); irq_req = 0; local_mem = 1; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic slot(input string rq, input logic ld, input logic fst, input logic [31:0] p,
                      input logic cl, input logic rt, input logic isr,
                      input logic exp_c, input int exp_pc, input int exp_irq = -1);
    slot_valid = 1; load_en = ld; load_fast = fst; load_pat = p;
    call_exec = cl; ret_exec = rt; isr_active = isr;
    #1;
    chk({rq, " cancel"}, {31'b0, cancel}, {31'b0, exp_c});
    chk({rq, " pc_adv"}, {26'b0, pc_adv}, exp_pc);
    if (exp_irq >= 0) chk({rq, " irq_accept"}, {31'b0, irq_accept}, exp_irq);
    @(negedge clk);
    quiet();
  endtask

  task automatic t_reset;
    do_reset();
    chk("R10 status", status, 32'h0);
    slot("R10 idle slot", 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_cancel;
    do_reset();
    slot("R2 load", 1, 0, 32'h5, 0, 0, 0, 0, 1);
    chk("R9 status 0x5", status, 32'h8140_0000);
    slot("R1 b0", 0, 0, 0, 0, 0, 0, 1, 1);
    slot("R1 b1", 0, 0, 0, 0, 0, 0, 0, 1);
    slot("R1 b2", 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R2 drained", status, 32'h0);
    slot("R2 idle after", 0, 0, 0, 0, 0, 0, 0, 1);
    slot("R2 load 3", 1, 0, 32'h3, 0, 0, 0, 0, 1);
    slot("R2 load in cancelled slot", 1, 0, 32'h0, 0, 0, 0, 1, 1);
    slot("R2 ignored load", 0, 0, 0, 0, 0, 0, 1, 1);
    slot("R2 end", 0, 0, 0, 0, 0, 0, 0, 1);
    slot("R2 zero load", 1, 0, 32'h0, 0, 0, 0, 0, 1);
    chk("R2 zero idle", status, 32'h0);
  endtask

  task automatic t_fast;
    do_reset();
    slot("R3 load 0x67", 1, 1, 32'h67, 0, 0, 0, 0, 4);
    chk("R3 status", status, 32'h8300_0000);
    slot("R3 no run", 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R3 status2", status, 32'h8180_0000);
    slot("R3 run of 2", 0, 0, 0, 0, 0, 0, 0, 3);
    slot("R3 after", 0, 0, 0, 0, 0, 0, 0, 1);
    slot("R3 all ones", 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 33);
    chk("R3 all ones drained", status, 32'h0);
  endtask

  task automatic t_hub;
    do_reset();
    local_mem = 0;
    slot("R4 load", 1, 1, 32'h3, 0, 0, 0, 0, 1);
    slot("R4 b0", 0, 0, 0, 0, 0, 0, 1, 1);
    slot("R4 b1", 0, 0, 0, 0, 0, 0, 1, 1);
    slot("R4 b2", 0, 0, 0, 0, 0, 0, 0, 1);
    local_mem = 1;
  endtask

  task automatic t_isr;
    do_reset();
    slot("R5 load", 1, 0, 32'hA, 0, 0, 0, 0, 1);
    chk("R5 status", status, 32'h8280_0000);
    slot("R5 isr load", 1, 0, 32'hF, 0, 0, 1, 0, 1);
    slot("R5 isr call", 0, 0, 0, 1, 0, 1, 0, 1);
    chk("R5 held", status, 32'h8280_0000);
    slot("R5 resume b0", 0, 0, 0, 0, 0, 0, 0, 1);
    slot("R5 resume b1", 0, 0, 0, 0, 0, 0, 1, 1);
    slot("R5 resume b2", 0, 0, 0, 0, 0, 0, 0, 1);
    slot("R5 resume b3", 0, 0, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_irq;
    do_reset();
    irq_req = 1;
    slot("R6 load", 1, 0, 32'h2, 0, 0, 0, 0, 1, 1);
    slot("R6 blocked", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    slot("R6 reopens", 0, 0, 0, 0, 0, 0, 1, 1, 1);
    irq_req = 0;
  endtask

  task automatic t_call;
    do_reset();
    slot("R7 load", 1, 0, 32'hC, 0, 0, 0, 0, 1);
    slot("R7 call", 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R7 frozen", status, 32'h0);
    slot("R7 sub a", 0, 0, 0, 0, 0, 0, 0, 1);
    slot("R7 ret", 0, 0, 0, 0, 1, 0, 0, 1);
    chk("R7 restored", status, 32'h8180_0000);
    slot("R7 after b1", 0, 0, 0, 0, 0, 0, 0, 1);
    slot("R7 after b2", 0, 0, 0, 0, 0, 0, 1, 1);
    slot("R7 after b3", 0, 0, 0, 0, 0, 0, 1, 1);
    slot("R7 load 3", 1, 0, 32'h3, 0, 0, 0, 0, 1);
    slot("R7 skipped call", 0, 0, 0, 1, 0, 0, 1, 1);
    chk("R7 no freeze", status, 32'h8040_0000);
    slot("R7 still skipping", 0, 0, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_nest;
    do_reset();
    slot("R8 load 2", 1, 0, 32'h2, 0, 0, 0, 0, 1);
    slot("R8 empty ret", 0, 0, 0, 0, 1, 0, 0, 1);
    slot("R8 empty ret kept", 0, 0, 0, 0, 0, 0, 1, 1);
    slot("R8 load 4", 1, 0, 32'h4, 0, 0, 0, 0, 1);
    slot("R8 call1", 0, 0, 0, 1, 0, 0, 0, 1);
    slot("R8 inner load", 1, 0, 32'h2, 0, 0, 0, 0, 1);
    slot("R8 call2", 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R8 frozen2", status, 32'h0);
    slot("R8 ret2", 0, 0, 0, 0, 1, 0, 0, 1);
    chk("R8 inner restored", status, 32'h8040_0000);
    slot("R8 inner skip", 0, 0, 0, 0, 0, 0, 1, 1);
    slot("R8 ret1", 0, 0, 0, 0, 1, 0, 0, 1);
    chk("R8 outer restored", status, 32'h8080_0000);
  endtask

  task automatic t_status;
    do_reset();
    slot("R9 load high", 1, 0, 32'h600, 0, 0, 0, 0, 1);
    chk("R9 ones above window", status, 32'h8000_0000);
    do_reset();
    slot("R9 load 1ff", 1, 0, 32'h1FF, 0, 0, 0, 0, 1);
    chk("R9 full window", status, 32'hFFC0_0000);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    quiet(); irq_req = 0; local_mem = 1; rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cancel();
    t_fast();
    t_hub();
    t_isr();
    t_irq();
    t_call();
    t_nest();
    t_status();
    summary();
    $finish;
  end
endmodule